// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit register datapath and a memory that is organised as 32-bit words. A request carries a byte address, an access size (byte, halfword or word), a read/write direction and, for reads, a flag that chooses zero extension over sign extension. The memory sees the word address, a per-lane write enable and a write-data bus. On that bus the store operand is copied into every lane that the access could address.

Memory answers a read one cycle after the request. The block keeps the low address bits, the size and the extension flag from the request cycle. In the next cycle it uses them to pick the addressed bytes out of the returned word and widen them to 32 bits. Lanes are numbered little-endian: the byte at the lowest address is the least significant byte of the word. An access whose address is not a multiple of its size is not performed. It raises an address-error flag instead.

Top module: `lsu_lane_align`

## Requirements
- R1: Lane order is little-endian. Address offset k (the low two address bits) selects bits [8k+7:8k] of the memory word, for both reads and writes.
- R2: The size code is 2'b00 byte, 2'b01 halfword, 2'b10 word, and 2'b11 is reserved. `addr_err_o` is 1 in the request cycle when `req_valid_i` is high and any of these holds: a halfword has an odd address, a word has an address that is not a multiple of 4, or the size is reserved. Otherwise `addr_err_o` is 0.
- R3: When `addr_err_o` is 1, `mem_req_o` is 0 and `mem_be_o` is 4'b0000, so memory is left untouched.
- R4: For an accepted request, `mem_be_o` is 4'b0001 shifted left by the offset for a byte, 4'b0011 shifted left by the offset for a halfword, and 4'b1111 for a word. It is 4'b0000 whenever no request is accepted. This holds for reads and writes alike.
- R5: For a store, `mem_wdata_o` is the low byte of `req_wdata_i` copied into all four lanes for a byte, the low halfword copied into both halves for a halfword, and `req_wdata_i` unchanged for a word. The unused upper operand bits have no effect.
- R6: With `req_unsigned_i` at 0, a byte or halfword read is sign-extended. For example, word 0xABCDE080 at offset 0 reads as 0xFFFFFF80 for a byte and as 0xFFFFE080 for a halfword.
- R7: With `req_unsigned_i` at 1, a byte or halfword read is zero-extended. The same word reads as 0x00000080 and 0x0000E080.
- R8: `ld_valid_o` is 1 in exactly the cycle after an accepted read request. While it is 1, `ld_data_o` is computed combinationally from `mem_rdata_i` in that cycle. Stores and errored requests never raise `ld_valid_o`.
- R9: `mem_addr_o` is `req_addr_i` with the low two bits cleared, and `mem_we_o` follows `req_write_i`.
- R10: While `rst_ni` is low, and after it is released, `ld_valid_o` is 0 until a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 store, 0 load |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | 00 byte, 01 half, 10 word, 11 reserved |
| req_unsigned_i | input | 1 | Load zero-extends when 1 |
| req_wdata_i | input | 32 | Store operand from register |
| mem_rdata_i | input | 32 | Word returned by memory one cycle after a read |
| mem_req_o | output | 1 | Accepted access to memory |
| mem_we_o | output | 1 | Write strobe direction |
| mem_addr_o | output | ADDR_W | Word-aligned address |
| mem_be_o | output | 4 | Per-lane enable |
| mem_wdata_o | output | 32 | Lane-replicated store data |
| addr_err_o | output | 1 | Misaligned or reserved-size request |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extended load result |

## Verification
Some properties are checked on every cycle. An error flag always blocks the memory access and clears every lane enable. An accepted byte access enables exactly one lane, and a halfword access enables exactly two. A granted word access is always aligned. A load-valid pulse always follows an accepted read, and an unsigned byte result has its upper bits clear. Other behaviour needs the bench's sweep over every size, extension mode and offset, with several data patterns per combination. That behaviour is the exact lane positions, the replicated write data, and the selected and extended read values.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic [OFF_W-1:0] off;
    acc_size_e        size;
    logic             uns;
  } ld_ctrl_t;
endpackage

// File: rtl/lane_align_chk.sv
module lane_align_chk
  import lane_pkg::*;
(
  input  logic             valid_i,
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             err_o,
  output logic             ok_o,
  output logic [LANES-1:0] be_o
);
  logic [OFF_W:0] nbytes;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: err_o = 1'b0;
      SZ_HALF: err_o = off_i[0];
      SZ_WORD: err_o = |off_i;
      default: err_o = 1'b1;
    endcase
    err_o = err_o & valid_i;
    ok_o  = valid_i & ~err_o;
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: nbytes = (OFF_W+1)'(1);
      SZ_HALF: nbytes = (OFF_W+1)'(2);
      default: nbytes = (OFF_W+1)'(LANES);
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [OFF_W:0] lo, hi;
    assign lo = {1'b0, off_i};
    assign hi = lo + nbytes;
    assign be_o[k] = ok_o && ((OFF_W+1)'(k) >= lo) && ((OFF_W+1)'(k) < hi);
  end

  // R4
  byte_one_lane_chk: assert property (@(be_o) (ok_o && size_i == SZ_BYTE) |-> $countones(be_o) == 1);
endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer
  import lane_pkg::*;
(
  input  acc_size_e          size_i,
  input  logic [WORD_W-1:0]  reg_i,
  output logic [WORD_W-1:0]  wdata_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[8*k +: 8] = reg_i[7:0];
        SZ_HALF: wdata_o[8*k +: 8] = reg_i[8*(k%2) +: 8];
        default: wdata_o[8*k +: 8] = reg_i[8*k +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lane_pkg::*;
(
  input  ld_ctrl_t           ctrl_i,
  input  logic [WORD_W-1:0]  rdata_i,
  output logic [WORD_W-1:0]  data_o
);
  logic [WORD_W-1:0] shifted;
  logic              fill_b, fill_h;

  assign shifted = rdata_i >> {ctrl_i.off, 3'b000};
  assign fill_b  = ~ctrl_i.uns & shifted[7];
  assign fill_h  = ~ctrl_i.uns & shifted[15];

  always_comb begin
    unique case (ctrl_i.size)
      SZ_BYTE: data_o = {{(WORD_W-8){fill_b}}, shifted[7:0]};
      SZ_HALF: data_o = {{(WORD_W-16){fill_h}}, shifted[15:0]};
      default: data_o = shifted;
    endcase
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_unsigned_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  output logic              addr_err_o,
  output logic              ld_valid_o,
  output logic [31:0]       ld_data_o
);
  acc_size_e        size;
  logic [OFF_W-1:0] off;
  logic             ok;
  ld_ctrl_t         ld_ctrl_q;

  assign size = acc_size_e'(req_size_i);
  assign off  = req_addr_i[OFF_W-1:0];

  lane_align_chk u_align (
    .valid_i (req_valid_i),
    .size_i  (size),
    .off_i   (off),
    .err_o   (addr_err_o),
    .ok_o    (ok),
    .be_o    (mem_be_o)
  );

  lane_store_steer u_steer (
    .size_i  (size),
    .reg_i   (req_wdata_i),
    .wdata_o (mem_wdata_o)
  );

  assign mem_req_o  = ok;
  assign mem_we_o   = req_write_i;
  assign mem_addr_o = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      ld_ctrl_q  <= '0;
    end else begin
      ld_valid_o <= ok & ~req_write_i;
      if (ok && !req_write_i) ld_ctrl_q <= '{off: off, size: size, uns: req_unsigned_i};
    end
  end

  lane_load_extract u_extract (
    .ctrl_i  (ld_ctrl_q),
    .rdata_i (mem_rdata_i),
    .data_o  (ld_data_o)
  );

  // R3
  err_blocks_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> (!mem_req_o && mem_be_o == 4'b0000));
  // R2
  word_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && size == SZ_WORD) |-> (req_addr_i[1:0] == 2'b00));
  // R4
  half_two_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && size == SZ_HALF) |-> $countones(mem_be_o) == 2);
  // R8
  ld_valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> ld_valid_o);
  // R8
  no_spurious_ld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && !mem_we_o) |=> !ld_valid_o);
  // R7
  uns_byte_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_o && ld_ctrl_q.uns && ld_ctrl_q.size == SZ_BYTE) |-> ld_data_o[31:8] == 24'h0);
endmodule

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_uns = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
  logic [1:0]  req_size = '0;
  logic        mem_req, mem_we, addr_err, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lsu_lane_align u_lsu_lane_align (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_unsigned_i(req_uns),
    .req_wdata_i(req_wdata), .mem_rdata_i(mem_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .addr_err_o(addr_err), .ld_valid_o(ld_valid),
    .ld_data_o(ld_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_load(logic [31:0] w, int off, int sz, bit uns);
    logic [31:0] s = w >> (8*off);
    if (sz == 0) return uns ? {24'h0, s[7:0]} : {{24{s[7]}}, s[7:0]};
    if (sz == 1) return uns ? {16'h0, s[15:0]} : {{16{s[15]}}, s[15:0]};
    return w;
  endfunction

  task automatic run(bit wr, int sz, bit uns, int off, logic [31:0] pat, logic [31:0] base);
    bit          err;
    logic [3:0]  be;
    logic [31:0] wd;
    err = (sz == 3) || (sz == 1 && off % 2 != 0) || (sz == 2 && off != 0);
    be  = err ? 4'h0 : (sz == 0) ? 4'h1 << off : (sz == 1) ? 4'h3 << off : 4'hF;
    wd  = (sz == 0) ? {4{pat[7:0]}} : (sz == 1) ? {2{pat[15:0]}} : pat;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_uns = uns;
    req_addr = base + 32'(off); req_wdata = pat;
    #1;
    check("R2 addr_err", {31'h0, addr_err}, {31'h0, err});
    check("R3/R4 mem_be", {28'h0, mem_be}, {28'h0, be});
    check("R3 mem_req", {31'h0, mem_req}, {31'h0, !err});
    check("R9 mem_addr", mem_addr, base);
    check("R9 mem_we", {31'h0, mem_we}, {31'h0, wr});
    if (wr && !err && sz != 3) check("R5/R1 mem_wdata", mem_wdata, wd);
    @(negedge clk);
    req_valid = 1'b0; req_wdata = '0; mem_rdata = pat;
    #1;
    check("R8 ld_valid", {31'h0, ld_valid}, {31'h0, !wr && !err});
    if (!wr && !err) check(uns ? "R7/R1 ld_data" : "R6/R1 ld_data", ld_data, ref_load(pat, off, sz, uns));
  endtask

  initial begin
    logic [31:0] pats [4] = '{32'hABCDE080, 32'h11223344, 32'h7F80017F, 32'h00FF8000};
    #2;
    check("R10 ld_valid in reset", {31'h0, ld_valid}, 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R10 ld_valid after reset", {31'h0, ld_valid}, 32'h0);
    check("R4 idle be", {28'h0, mem_be}, 32'h0);
    // R6 R7: document example word at offset 0
    run(0, 1, 0, 0, 32'hABCDE080, 32'h1000_0000);
    run(0, 0, 0, 0, 32'hABCDE080, 32'h1000_0000);
    run(0, 1, 1, 0, 32'hABCDE080, 32'h1000_0000);
    run(0, 0, 1, 0, 32'hABCDE080, 32'h1000_0000);
    foreach (pats[p])
      for (int wr = 0; wr < 2; wr++)
        for (int sz = 0; sz < 4; sz++)
          for (int u = 0; u < 2; u++)
            for (int off = 0; off < 4; off++)
              run(wr[0], sz, u[0], off, pats[p], 32'h0040_0000 + 32'(p*16));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule